// File: doc/BRIEF.md
# Bus Owner Register and Event Notification Unit

This unit sits in an audio streaming device on a serial bus and keeps three pieces of global state. The first is a 64-bit owner register naming the bus node, and the address inside that node, that should receive event notifications. The second is a notification register holding the most recent batch of events. The third is the global stream-enable register. A controller may claim ownership only with an atomic compare-and-swap. Plain writes to the owner register are refused.

When any bit of the event vector is high in a cycle, that cycle is one event batch. The batch overwrites the notification register, so bits from earlier batches are lost. If an owner is set, the unit also raises an outbound quadlet-write request that carries the mask to the owner's node and offset. That request stays valid until the bus side accepts it. A newer batch that arrives before then replaces the pending mask. A bus-reset pulse drops ownership, stops streaming and cancels any pending request.

Register accesses take one cycle. The access is presented with `reg_req_i`, and its response (`reg_rvalid_o`, `reg_rdata_o`, `reg_err_o`) appears on the following cycle.

Top module: `owner_notify_unit`

## Requirements
- R1: After reset, and in the cycle after a bus-reset pulse, the owner register reads 0xFFFF000000000000 (no owner) and `streams_run_o` is 0.
- R2: A compare-and-swap (op=2) to the owner register (sel=0) returns the old owner value. It stores `reg_wdata_i` only when the old value equals `reg_cmp_i`.
- R3: A plain write (op=1) to the owner register is answered with `reg_err_o`=1 and leaves the owner value unchanged.
- R4: An event batch (any bit of `evt_i` high) replaces the notification register (sel=1) with exactly that batch. Earlier bits are not kept. Event bits: 0 receive config changed, 1 transmit config changed, 4 current-source lock changed, 5 clock-select accepted, 6 some source lock changed. Other bits are device-specific.
- R5: With an owner set, an event batch raises `nw_valid_o` on the next cycle. It carries node = owner[63:48], offset = owner[47:0], and data = the batch, using the owner value held before that edge.
- R6: With no owner set, an event batch updates the notification register but raises no request.
- R7: `nw_valid_o` stays high until `nw_ready_i` is high. A batch that arrives while a request is pending replaces its mask. A batch that arrives in the cycle the pending request is accepted becomes a new request.
- R8: A write (op=1) to the enable register (sel=2) with any non-zero value in bits [31:0] sets `streams_run_o` to 1. Writing zero clears it. A read returns it in bit 0.
- R9: A bus-reset pulse cancels a pending outbound request.
- R10: Writes and compare-and-swaps to the notification register, compare-and-swaps to the enable register, and accesses with sel=3 all answer `reg_err_o`=1 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle bus-reset pulse |
| reg_req_i | input | 1 | Register access strobe |
| reg_op_i | input | 2 | 0 read, 1 write, 2 compare-and-swap |
| reg_sel_i | input | 2 | 0 owner, 1 notification, 2 enable |
| reg_wdata_i | input | 64 | Write data or swap value |
| reg_cmp_i | input | 64 | Compare operand |
| reg_rvalid_o | output | 1 | Response valid, one cycle after the strobe |
| reg_rdata_o | output | 64 | Read data or old value |
| reg_err_o | output | 1 | Access refused |
| evt_i | input | EVT_W | Event batch vector |
| nw_valid_o | output | 1 | Outbound notification write pending |
| nw_ready_i | input | 1 | Outbound write accepted |
| nw_node_o | output | 16 | Destination node ID |
| nw_offset_o | output | 48 | Destination offset |
| nw_data_o | output | 32 | Notification mask |
| streams_run_o | output | 1 | Global stream enable |

## Verification
Two functions can meet in a single cycle: a new event batch, and the acceptance of the request still pending from an earlier batch. The bench holds `nw_ready_i` low after one batch. It then raises ready in the same cycle that it presents a second batch. The scoreboard must first see the first mask accepted, and then a fresh request carrying the second mask, with nothing lost or repeated. A bus-reset pulse that lands on a pending request is checked the same way: the request must vanish and must never reach the scoreboard.

// File: rtl/own_ntf_pkg.sv
package own_ntf_pkg;
  localparam int OWN_W  = 64;
  localparam int NODE_W = 16;
  localparam int OFF_W  = OWN_W - NODE_W;
  localparam int NTF_W  = 32;
  localparam logic [OWN_W-1:0] NO_OWNER = {{NODE_W{1'b1}}, {OFF_W{1'b0}}};

  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_CAS = 2'd2, OP_RSV = 2'd3} reg_op_e;
  typedef enum logic [1:0] {SEL_OWN = 2'd0, SEL_NTF = 2'd1, SEL_EN = 2'd2, SEL_NONE = 2'd3} reg_sel_e;
endpackage

// File: rtl/own_cas_reg.sv
module own_cas_reg
  import own_ntf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset_i,
  input  logic             cas_i,
  input  logic             wr_try_i,
  input  logic [OWN_W-1:0] cmp_i,
  input  logic [OWN_W-1:0] swap_i,
  output logic [OWN_W-1:0] owner_o
);
  logic [OWN_W-1:0] own_q, own_d;
  logic             own_en;

  always_comb begin
    own_en = 1'b0;
    own_d  = own_q;
    if (bus_reset_i) begin
      own_en = 1'b1;
      own_d  = NO_OWNER;
    end else if (cas_i && (own_q == cmp_i)) begin
      own_en = 1'b1;
      own_d  = swap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= NO_OWNER;
    else if (own_en) own_q <= own_d;
  end

  assign owner_o = own_q;

  assert_busrst_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> owner_o == NO_OWNER);
  assert_cas_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_i && !bus_reset_i && (cmp_i != owner_o)) |=> owner_o == $past(owner_o));
  assert_plain_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_try_i && !bus_reset_i) |=> owner_o == $past(owner_o));
endmodule

// File: rtl/stream_en_reg.sv
module stream_en_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset_i,
  input  logic wr_i,
  input  logic nonzero_i,
  output logic run_o
);
  logic run_q, run_d, run_en;

  always_comb begin
    run_en = bus_reset_i | wr_i;
    run_d  = bus_reset_i ? 1'b0 : nonzero_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end

  assign run_o = run_q;

  assert_busrst_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> !run_o);
  assert_run_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !bus_reset_i) |=> run_o == $past(nonzero_i));
endmodule

// File: rtl/ntf_event_engine.sv
module ntf_event_engine
  import own_ntf_pkg::*;
#(
  parameter int EVT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [OWN_W-1:0]  owner_i,
  input  logic              nw_ready_i,
  output logic [NTF_W-1:0]  ntf_o,
  output logic              nw_valid_o,
  output logic [NODE_W-1:0] nw_node_o,
  output logic [OFF_W-1:0]  nw_offset_o,
  output logic [NTF_W-1:0]  nw_data_o
);
  logic [NTF_W-1:0] evt_ext;

  generate
    if (EVT_W < NTF_W) begin : g_pad
      assign evt_ext = {{(NTF_W-EVT_W){1'b0}}, evt_i};
    end else begin : g_cut
      assign evt_ext = evt_i[NTF_W-1:0];
    end
  endgenerate

  logic             has_evt, owner_set, fire;
  logic [NTF_W-1:0] ntf_q, ntf_d;
  logic             vld_q, vld_d;
  logic [OWN_W-1:0] dst_q, dst_d;
  logic [NTF_W-1:0] dat_q, dat_d;
  logic             ld_en;

  always_comb begin
    has_evt   = |evt_ext;
    owner_set = (owner_i != NO_OWNER);
    fire      = vld_q & nw_ready_i;
    ntf_d     = has_evt ? evt_ext : ntf_q;
    ld_en     = 1'b0;
    dst_d     = dst_q;
    dat_d     = dat_q;
    vld_d     = vld_q;
    if (bus_reset_i) begin
      vld_d = 1'b0;
    end else if (has_evt && owner_set) begin
      vld_d = 1'b1;
      ld_en = 1'b1;
      dst_d = owner_i;
      dat_d = evt_ext;
    end else if (fire) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_q <= '0;
      vld_q <= 1'b0;
      dst_q <= NO_OWNER;
      dat_q <= '0;
    end else begin
      if (has_evt) ntf_q <= ntf_d;
      vld_q <= vld_d;
      if (ld_en) begin
        dst_q <= dst_d;
        dat_q <= dat_d;
      end
    end
  end

  assign ntf_o       = ntf_q;
  assign nw_valid_o  = vld_q;
  assign nw_node_o   = dst_q[OWN_W-1:OFF_W];
  assign nw_offset_o = dst_q[OFF_W-1:0];
  assign nw_data_o   = dat_q;

  assert_replace_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ntf_o == $past(evt_ext));
  assert_no_owner_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_i) && (owner_i == NO_OWNER) && !nw_valid_o && !bus_reset_i) |=> !nw_valid_o);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nw_valid_o && !nw_ready_i && !bus_reset_i) |=> nw_valid_o);
  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> !nw_valid_o);
endmodule

// File: rtl/owner_notify_unit.sv
module owner_notify_unit
  import own_ntf_pkg::*;
#(
  parameter int EVT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic              reg_req_i,
  input  logic [1:0]        reg_op_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [OWN_W-1:0]  reg_wdata_i,
  input  logic [OWN_W-1:0]  reg_cmp_i,
  output logic              reg_rvalid_o,
  output logic [OWN_W-1:0]  reg_rdata_o,
  output logic              reg_err_o,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              nw_valid_o,
  input  logic              nw_ready_i,
  output logic [NODE_W-1:0] nw_node_o,
  output logic [OFF_W-1:0]  nw_offset_o,
  output logic [NTF_W-1:0]  nw_data_o,
  output logic              streams_run_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  reg_op_e  op;
  reg_sel_e sel;
  assign op  = reg_op_e'(reg_op_i);
  assign sel = reg_sel_e'(reg_sel_i);

  logic             own_cas, own_wr, en_wr, acc_err;
  logic [OWN_W-1:0] owner;
  logic [NTF_W-1:0] ntf;

  always_comb begin
    own_cas = reg_req_i && (op == OP_CAS) && (sel == SEL_OWN);
    own_wr  = reg_req_i && (op == OP_WR)  && (sel == SEL_OWN);
    en_wr   = reg_req_i && (op == OP_WR)  && (sel == SEL_EN);
    unique case (sel)
      SEL_OWN: acc_err = (op == OP_WR) || (op == OP_RSV);
      SEL_NTF: acc_err = (op != OP_RD);
      SEL_EN:  acc_err = (op == OP_CAS) || (op == OP_RSV);
      default: acc_err = 1'b1;
    endcase
  end

  own_cas_reg u_owner (
    .clk(clk), .rst_n(rst_i_n), .bus_reset_i(bus_reset_i),
    .cas_i(own_cas), .wr_try_i(own_wr),
    .cmp_i(reg_cmp_i), .swap_i(reg_wdata_i), .owner_o(owner)
  );

  stream_en_reg u_enable (
    .clk(clk), .rst_n(rst_i_n), .bus_reset_i(bus_reset_i),
    .wr_i(en_wr), .nonzero_i(|reg_wdata_i[NTF_W-1:0]), .run_o(streams_run_o)
  );

  ntf_event_engine #(.EVT_W(EVT_W)) u_events (
    .clk(clk), .rst_n(rst_i_n), .bus_reset_i(bus_reset_i),
    .evt_i(evt_i), .owner_i(owner), .nw_ready_i(nw_ready_i),
    .ntf_o(ntf), .nw_valid_o(nw_valid_o), .nw_node_o(nw_node_o),
    .nw_offset_o(nw_offset_o), .nw_data_o(nw_data_o)
  );

  // response path
  logic             rv_d, er_d;
  logic [OWN_W-1:0] rd_d;
  always_comb begin
    rv_d = reg_req_i;
    er_d = reg_req_i && acc_err;
    rd_d = '0;
    if (reg_req_i && !acc_err) begin
      unique case (sel)
        SEL_OWN: rd_d = owner;
        SEL_NTF: rd_d = {{(OWN_W-NTF_W){1'b0}}, ntf};
        SEL_EN:  rd_d = {{(OWN_W-1){1'b0}}, streams_run_o};
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      reg_rvalid_o <= 1'b0;
      reg_err_o    <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      reg_rvalid_o <= rv_d;
      reg_err_o    <= er_d;
      if (reg_req_i) reg_rdata_o <= rd_d;
    end
  end

  assert_cas_old_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    own_cas |=> reg_rdata_o == $past(owner));
  assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_req_i && (sel == SEL_NTF) && (op != OP_RD)) |=> reg_err_o);
endmodule

// File: tb/test_owner_notify_unit.sv
module test_owner_notify_unit;
  import own_ntf_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset_i = 1'b0;
  logic reg_req_i = 1'b0;
  logic [1:0] reg_op_i = 2'd0, reg_sel_i = 2'd0;
  logic [63:0] reg_wdata_i = '0, reg_cmp_i = '0;
  logic reg_rvalid_o, reg_err_o;
  logic [63:0] reg_rdata_o;
  logic [31:0] evt_i = '0;
  logic nw_valid_o;
  logic nw_ready_i = 1'b0;
  logic [15:0] nw_node_o;
  logic [47:0] nw_offset_o;
  logic [31:0] nw_data_o;
  logic streams_run_o;

  int vec = 0, bad = 0;
  bit done = 0;
  logic [95:0] expq[$];

  always #10 clk = ~clk;

  owner_notify_unit i_owner_notify_unit (.*);

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares every accepted outbound write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && nw_valid_o && nw_ready_i) begin
      if (expq.size() == 0) chk("R5/R7 unexpected request", {nw_node_o, nw_offset_o, nw_data_o}, '0);
      else chk("R5/R7 request", {nw_node_o, nw_offset_o, nw_data_o}, expq.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic acc(input logic [1:0] op, input logic [1:0] sel, input logic [63:0] wd,
                     input logic [63:0] cmp, output logic [63:0] rd, output logic er);
    reg_req_i = 1'b1; reg_op_i = op; reg_sel_i = sel; reg_wdata_i = wd; reg_cmp_i = cmp;
    step();
    reg_req_i = 1'b0;
    rd = reg_rdata_o; er = reg_err_o;
  endtask

  task automatic pulse_evt(input logic [31:0] m);
    evt_i = m; step(); evt_i = '0;
  endtask

  localparam logic [63:0] OWN_A = 64'h0012_0000_ABCD_0040;
  localparam logic [63:0] OWN_B = 64'h0007_0000_0000_1000;

  initial begin
    logic [63:0] rd;
    logic er;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    acc(2'd0, 2'd0, '0, '0, rd, er);
    chk("R1 owner after reset", rd, NO_OWNER);
    chk("R1 run after reset", streams_run_o, 0);
    // R8 enable
    acc(2'd1, 2'd2, 64'd5, '0, rd, er);
    chk("R8 run after nonzero write", streams_run_o, 1);
    acc(2'd1, 2'd2, 64'd0, '0, rd, er);
    chk("R8 run after zero write", streams_run_o, 0);
    acc(2'd1, 2'd2, 64'h100, '0, rd, er);
    acc(2'd0, 2'd2, '0, '0, rd, er);
    chk("R8 enable readback", rd, 64'd1);
    // R6 no owner: register updated, no request
    pulse_evt(32'h0000_0010);
    chk("R6 no request without owner", nw_valid_o, 0);
    step();
    chk("R6 still no request", nw_valid_o, 0);
    acc(2'd0, 2'd1, '0, '0, rd, er);
    chk("R6 notify updated", rd, 64'h10);
    // R2 claim
    acc(2'd2, 2'd0, OWN_A, NO_OWNER, rd, er);
    chk("R2 cas returns old", rd, NO_OWNER);
    acc(2'd2, 2'd0, OWN_B, NO_OWNER, rd, er);
    chk("R2 cas miss returns current", rd, OWN_A);
    acc(2'd0, 2'd0, '0, '0, rd, er);
    chk("R2 owner after miss", rd, OWN_A);
    // R3 plain write refused
    acc(2'd1, 2'd0, OWN_B, '0, rd, er);
    chk("R3 plain write error", er, 1);
    acc(2'd0, 2'd0, '0, '0, rd, er);
    chk("R3 owner unchanged", rd, OWN_A);
    // R10 notify and sel=3 refused
    acc(2'd1, 2'd1, 64'hFF, '0, rd, er);
    chk("R10 notify write error", er, 1);
    acc(2'd0, 2'd3, '0, '0, rd, er);
    chk("R10 sel3 error", er, 1);
    acc(2'd0, 2'd1, '0, '0, rd, er);
    chk("R10 notify unchanged", rd, 64'h10);
    // R5 request with owner set
    nw_ready_i = 1'b1;
    expq.push_back({OWN_A, 32'h13});
    pulse_evt(32'h13);
    step(); step();
    // R4 replacement
    expq.push_back({OWN_A, 32'h20});
    pulse_evt(32'h20);
    step(); step();
    acc(2'd0, 2'd1, '0, '0, rd, er);
    chk("R4 notify replaced", rd, 64'h20);
    // R7 hold and replace while pending
    nw_ready_i = 1'b0;
    pulse_evt(32'h01);
    step();
    chk("R7 held without ready", nw_valid_o, 1);
    pulse_evt(32'h02);
    expq.push_back({OWN_A, 32'h02});
    nw_ready_i = 1'b1;
    step(); step();
    chk("R7 drained", nw_valid_o, 0);
    // R7 new batch in the acceptance cycle
    nw_ready_i = 1'b0;
    pulse_evt(32'h40);
    expq.push_back({OWN_A, 32'h40});
    expq.push_back({OWN_A, 32'h60});
    evt_i = 32'h60; nw_ready_i = 1'b1;
    step(); evt_i = '0;
    chk("R7 new request after accept", nw_valid_o, 1);
    step(); step();
    chk("R7 queue consumed", expq.size(), 0);
    // R9/R1 bus reset
    nw_ready_i = 1'b0;
    pulse_evt(32'h04);
    bus_reset_i = 1'b1; step(); bus_reset_i = 1'b0;
    chk("R9 request cancelled", nw_valid_o, 0);
    chk("R1 run cleared by bus reset", streams_run_o, 0);
    nw_ready_i = 1'b1;
    step(); step();
    acc(2'd0, 2'd0, '0, '0, rd, er);
    chk("R1 owner cleared by bus reset", rd, NO_OWNER);
    chk("R9 nothing left", expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule